// File: doc/BRIEF.md
# Deinterleaving Ping-Pong Frame Buffer

This block sits between a time-division-multiplexed sample stream and a processor that works on whole frames. Each incoming word carries a slot tag that names its channel, and one word per channel arrives in every TDM frame. The block places each word at `slot * CH_LEN + position` inside one of two receive buffers, so every channel ends up in a contiguous run of `CH_LEN` samples. When the last slot of the last position arrives, the block reports the finished buffer, hands it to the processor, and continues into the other buffer.

The transmit direction mirrors this. The processor writes per-channel-contiguous results into the transmit buffer whose index matches the receive buffer it is working on. The stream side reads the other transmit buffer back in interleaved slot order. Both directions swap on the same frame boundary, so the processor always holds a matching input/output pair.

The processor gives a buffer back with a release pulse. If a buffer is handed over again before it has been released, the handover carries an overrun pulse and the stream side overwrites it anyway. On the stream ports, `rx_ready` is high whenever the block is out of reset, so the receive side never applies back-pressure. `tx_valid` rises at the first buffer completion and stays high. While `tx_ready` is low, `tx_data` and `tx_slot` hold, except that a buffer swap restarts the transmit order.

Top module: `deint_pingpong_buffer`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `buf_ready`, `overrun`, `tx_valid` and `buf_idx` are 0. The first buffer filled is buffer 0.
- R2: A receive word accepted with slot tag s at frame position p is stored at offset s*CH_LEN+p of the active receive buffer. Once that buffer is complete, the processor reads the word at `proc_rd_addr` = s*CH_LEN+p.
- R3: A receive word whose slot tag is CH_COUNT or above is accepted but dropped. It writes nothing and does not advance the frame position.
- R4: The frame position advances after a word with slot tag CH_COUNT-1 is accepted. When that word is at position CH_LEN-1, `buf_ready` is high for exactly the one cycle after its accepting edge. At all other times it is low.
- R5: `buf_idx`, valid while `buf_ready` is high, is the index of the buffer just completed. Consecutive completions alternate between 0 and 1.
- R6: Processor reads return the most recently completed receive buffer, even while the stream side fills the other buffer. Processor writes go to the transmit buffer with that same index.
- R7: `tx_valid` is 0 until the first completion and 1 from then on. The n-th transmit word of a period carries slot n mod CH_COUNT and the transmit-buffer word at offset slot*CH_LEN + (n div CH_COUNT), taken from the buffer the processor filled during the previous period. After the last word, the order wraps to word 0.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_slot` stay unchanged, except across a buffer swap.
- R9: In the cycle after a completion, the transmit order restarts at slot 0, position 0 of the newly active transmit buffer, whatever position it had reached.
- R10: `overrun` pulses together with `buf_ready` when the previously handed-over buffer was not released by a `proc_release` pulse. A release in the same cycle as the completion counts as a release in time.
- R11: `rx_ready` is 0 while reset is asserted and 1 from the first clock edge after reset is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | Receive word present |
| rx_ready | output | 1 | Receive word accepted (high out of reset) |
| rx_data | input | DATA_W | Receive sample |
| rx_slot | input | SLOT_W | Channel tag of the receive sample |
| tx_valid | output | 1 | Transmit word present |
| tx_ready | input | 1 | Transmit word taken |
| tx_data | output | DATA_W | Transmit sample |
| tx_slot | output | SLOT_W | Channel tag of the transmit sample |
| proc_rd_addr | input | ADDR_W | Offset into the completed receive buffer |
| proc_rd_data | output | DATA_W | Word at `proc_rd_addr` (combinational) |
| proc_wr_en | input | 1 | Processor write strobe |
| proc_wr_addr | input | ADDR_W | Offset into the processor's transmit buffer |
| proc_wr_data | input | DATA_W | Processor write data |
| proc_release | input | 1 | Processor has finished with its buffer pair |
| buf_ready | output | 1 | One-cycle pulse: a buffer has completed |
| buf_idx | output | 1 | Index of the completed buffer |
| overrun | output | 1 | Pulse: completion while the previous buffer was still held |

## Verification
`buf_ready`, `buf_idx`, `overrun` and the rise of `tx_valid` all come from one register stage, so they are due one cycle after the edge that accepts the last word. `rx_ready` is due one cycle after reset is removed. `proc_rd_data` and `tx_data` are combinational reads of the buffers: the read value is due in the same cycle as its address, and the next transmit word appears one edge after a handshake. The bench drives every input on the falling edge and samples at the following falling edge. That is half a period after the edge that produces each registered result, and after combinational reads have settled. Each word is given its own two-phase handshake, so the expected cycle of every result is exact.

// File: rtl/dpp_pkg.sv
package dpp_pkg;

  localparam int DEF_CH_COUNT = 3;
  localparam int DEF_CH_LEN   = 8;
  localparam int DEF_DATA_W   = 16;

  // Offset of a channel's sample within one buffer: channels sit back to back.
  function automatic int unsigned slot_offset(input int unsigned slot,
                                              input int unsigned pos,
                                              input int unsigned len);
    return slot * len + pos;
  endfunction

  function automatic int unsigned width_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dpp_rx_sorter.sv
module dpp_rx_sorter
  import dpp_pkg::*;
#(
  parameter int CH_COUNT = DEF_CH_COUNT,
  parameter int CH_LEN   = DEF_CH_LEN,
  parameter int SLOT_W   = 2,
  parameter int POS_W    = 3,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [SLOT_W-1:0] slot,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_off,
  output logic              buf_done
);

  logic [POS_W-1:0] pos_q;
  logic slot_ok, slot_last, pos_last;

  always_comb begin
    slot_ok   = {1'b0, slot} < (SLOT_W+1)'(CH_COUNT);
    slot_last = slot == SLOT_W'(CH_COUNT - 1);
    pos_last  = pos_q == POS_W'(CH_LEN - 1);
    wr_en     = accept && slot_ok;
    wr_off    = ADDR_W'(slot_offset(32'(slot), 32'(pos_q), CH_LEN));
    buf_done  = accept && slot_last && pos_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (accept && slot_last) begin
      pos_q <= pos_last ? '0 : pos_q + 1'b1;
    end
  end

endmodule

// File: rtl/dpp_tx_merger.sv
module dpp_tx_merger
  import dpp_pkg::*;
#(
  parameter int CH_COUNT = DEF_CH_COUNT,
  parameter int CH_LEN   = DEF_CH_LEN,
  parameter int SLOT_W   = 2,
  parameter int POS_W    = 3,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              restart,
  output logic [SLOT_W-1:0] slot,
  output logic [ADDR_W-1:0] rd_off
);

  logic [SLOT_W-1:0] slot_q;
  logic [POS_W-1:0]  pos_q;
  logic slot_last, pos_last;

  always_comb begin
    slot_last = slot_q == SLOT_W'(CH_COUNT - 1);
    pos_last  = pos_q == POS_W'(CH_LEN - 1);
    slot      = slot_q;
    rd_off    = ADDR_W'(slot_offset(32'(slot_q), 32'(pos_q), CH_LEN));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      slot_q <= '0;
      pos_q  <= '0;
    end else if (take) begin
      if (slot_last) begin
        slot_q <= '0;
        pos_q  <= pos_last ? '0 : pos_q + 1'b1;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dpp_bank.sv
module dpp_bank #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 24,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic              wsel,
  input  logic [ADDR_W-1:0] woff,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rsel,
  input  logic [ADDR_W-1:0] roff,
  output logic [DATA_W-1:0] rdata
);

  localparam int IDX_W = ADDR_W + 1;

  logic [DATA_W-1:0] mem [2*DEPTH];
  logic [IDX_W-1:0]  widx, ridx;
  logic              w_in, r_in;

  always_comb begin
    w_in  = {1'b0, woff} < IDX_W'(DEPTH);
    r_in  = {1'b0, roff} < IDX_W'(DEPTH);
    widx  = wsel ? IDX_W'(woff) + IDX_W'(DEPTH) : IDX_W'(woff);
    ridx  = rsel ? IDX_W'(roff) + IDX_W'(DEPTH) : IDX_W'(roff);
    rdata = r_in ? mem[ridx] : '0;
  end

  always_ff @(posedge clk) begin
    if (we && w_in) mem[widx] <= wdata;
  end

endmodule

// File: rtl/dpp_ctrl.sv
module dpp_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic buf_done,
  input  logic release_in,
  output logic active,
  output logic rx_ready,
  output logic tx_valid,
  output logic buf_ready,
  output logic buf_idx,
  output logic overrun
);

  logic held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      held_q    <= 1'b0;
      rx_ready  <= 1'b0;
      tx_valid  <= 1'b0;
      buf_ready <= 1'b0;
      buf_idx   <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      rx_ready  <= 1'b1;
      buf_ready <= buf_done;
      overrun   <= buf_done && held_q && !release_in;
      if (buf_done) begin
        buf_idx  <= active;
        active   <= ~active;
        held_q   <= 1'b1;
        tx_valid <= 1'b1;
      end else if (release_in) begin
        held_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/deint_pingpong_buffer.sv
module deint_pingpong_buffer
  import dpp_pkg::*;
#(
  parameter int  CH_COUNT = DEF_CH_COUNT,
  parameter int  CH_LEN   = DEF_CH_LEN,
  parameter int  DATA_W   = DEF_DATA_W,
  localparam int DEPTH    = CH_COUNT * CH_LEN,
  localparam int SLOT_W   = width_of(CH_COUNT),
  localparam int POS_W    = width_of(CH_LEN),
  localparam int ADDR_W   = width_of(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [SLOT_W-1:0] rx_slot,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic [SLOT_W-1:0] tx_slot,
  input  logic [ADDR_W-1:0] proc_rd_addr,
  output logic [DATA_W-1:0] proc_rd_data,
  input  logic              proc_wr_en,
  input  logic [ADDR_W-1:0] proc_wr_addr,
  input  logic [DATA_W-1:0] proc_wr_data,
  input  logic              proc_release,
  output logic              buf_ready,
  output logic              buf_idx,
  output logic              overrun
);

  logic              active;
  logic              rx_accept, tx_take;
  logic              rx_wr_en, rx_done;
  logic [ADDR_W-1:0] rx_off, tx_off;

  assign rx_accept = rx_valid && rx_ready;
  assign tx_take   = tx_valid && tx_ready;

  dpp_rx_sorter #(
    .CH_COUNT(CH_COUNT), .CH_LEN(CH_LEN),
    .SLOT_W(SLOT_W), .POS_W(POS_W), .ADDR_W(ADDR_W)
  ) u_sort (
    .clk(clk), .rst_n(rst_n), .accept(rx_accept), .slot(rx_slot),
    .wr_en(rx_wr_en), .wr_off(rx_off), .buf_done(rx_done)
  );

  dpp_tx_merger #(
    .CH_COUNT(CH_COUNT), .CH_LEN(CH_LEN),
    .SLOT_W(SLOT_W), .POS_W(POS_W), .ADDR_W(ADDR_W)
  ) u_merge (
    .clk(clk), .rst_n(rst_n), .take(tx_take), .restart(rx_done),
    .slot(tx_slot), .rd_off(tx_off)
  );

  // Stream side owns buffer 'active'; the processor owns the other one.
  dpp_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rx_bank (
    .clk(clk), .we(rx_wr_en), .wsel(active), .woff(rx_off), .wdata(rx_data),
    .rsel(~active), .roff(proc_rd_addr), .rdata(proc_rd_data)
  );

  dpp_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_tx_bank (
    .clk(clk), .we(proc_wr_en), .wsel(~active), .woff(proc_wr_addr),
    .wdata(proc_wr_data), .rsel(active), .roff(tx_off), .rdata(tx_data)
  );

  dpp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .buf_done(rx_done), .release_in(proc_release),
    .active(active), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .buf_ready(buf_ready), .buf_idx(buf_idx), .overrun(overrun)
  );

endmodule

// File: rtl/dpp_checker.sv
module dpp_checker #(
  parameter int CH_COUNT = 3,
  parameter int SLOT_W   = 2,
  parameter int DATA_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [SLOT_W-1:0] rx_slot,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic [SLOT_W-1:0] tx_slot,
  input logic              buf_ready,
  input logic              buf_idx,
  input logic              overrun
);

  logic last_word, seen_q, last_idx_q;
  assign last_word = rx_valid && rx_ready && (rx_slot == SLOT_W'(CH_COUNT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q     <= 1'b0;
      last_idx_q <= 1'b0;
    end else if (buf_ready) begin
      seen_q     <= 1'b1;
      last_idx_q <= buf_idx;
    end
  end

  AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ready |=> !buf_ready); // R4
  AST_RDY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ready |-> $past(last_word)); // R4
  AST_IDX_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_ready && seen_q) |-> (buf_idx != last_idx_q)); // R5
  AST_OVR_AT_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> buf_ready); // R10
  AST_TXV_AT_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ready |-> tx_valid); // R7
  AST_TXV_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> tx_valid); // R7
  AST_TX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ready |-> (tx_slot == '0)); // R9
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !last_word) |=> ($stable(tx_data) && $stable(tx_slot))); // R8

endmodule

bind deint_pingpong_buffer dpp_checker #(
  .CH_COUNT(CH_COUNT), .SLOT_W(SLOT_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_slot(rx_slot), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_slot(tx_slot), .buf_ready(buf_ready),
  .buf_idx(buf_idx), .overrun(overrun)
);

// File: tb/tb_deint_pingpong_buffer.sv
`timescale 1ns/1ps
module tb_deint_pingpong_buffer;

  localparam int NCH = 3, LEN = 8, DW = 16, SW = 2, AW = 5, DEPTH = NCH * LEN;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, tx_ready = 0, proc_wr_en = 0, proc_release = 0;
  logic [DW-1:0] rx_data = '0, proc_wr_data = '0;
  logic [SW-1:0] rx_slot = '0;
  logic [AW-1:0] proc_rd_addr = '0, proc_wr_addr = '0;
  logic rx_ready, tx_valid, buf_ready, buf_idx, overrun;
  logic [DW-1:0] tx_data, proc_rd_data;
  logic [SW-1:0] tx_slot;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  deint_pingpong_buffer #(.CH_COUNT(NCH), .CH_LEN(LEN), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_slot(rx_slot), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_slot(tx_slot),
    .proc_rd_addr(proc_rd_addr), .proc_rd_data(proc_rd_data),
    .proc_wr_en(proc_wr_en), .proc_wr_addr(proc_wr_addr),
    .proc_wr_data(proc_wr_data), .proc_release(proc_release),
    .buf_ready(buf_ready), .buf_idx(buf_idx), .overrun(overrun)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] rx_word(input logic [DW-1:0] base, input int s, input int p);
    return base + DW'(s * 16 + p);
  endfunction

  task automatic send(input logic [SW-1:0] s, input logic [DW-1:0] d);
    @(negedge clk);
    rx_valid = 1; rx_slot = s; rx_data = d;
    @(negedge clk);
    rx_valid = 0;
  endtask

  // Fill one receive buffer, check completion, then read it back.
  task automatic fill(input logic [DW-1:0] base, input bit bad, input logic exp_idx,
                      input logic exp_ovr, input bit chk_prev, input logic [DW-1:0] prev);
    for (int p = 0; p < LEN; p++) begin
      for (int s = 0; s < NCH; s++) begin
        send(SW'(s), rx_word(base, s, p));
        if (bad && p == 2 && s == 1) begin
          send(2'd3, 16'hDEAD);
          chk("R3 dropped slot leaves no completion", buf_ready, 0);
        end
        if (!(p == LEN-1 && s == NCH-1)) chk("R4 ready low mid-buffer", buf_ready, 0);
      end
      if (chk_prev && p == 0) begin
        proc_rd_addr = '0; #0.5;
        chk("R6 processor sees completed buffer", proc_rd_data, rx_word(prev, 0, 0));
      end
    end
    chk("R4 ready pulse", buf_ready, 1);
    chk("R5 buffer index", buf_idx, exp_idx);
    chk("R10 overrun flag", overrun, exp_ovr);
    chk("R7 tx valid after completion", tx_valid, 1);
    chk("R9 tx slot restart", tx_slot, 0);
    @(negedge clk);
    chk("R4 ready one cycle", buf_ready, 0);
    chk("R10 overrun one cycle", overrun, 0);
    for (int a = 0; a < DEPTH; a++) begin
      proc_rd_addr = AW'(a); #0.5;
      chk("R2 sorted word", proc_rd_data, rx_word(base, a / LEN, a % LEN));
    end
  endtask

  task automatic proc_fill(input logic [DW-1:0] base);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      proc_wr_en = 1; proc_wr_addr = AW'(a); proc_wr_data = base + DW'(a);
    end
    @(negedge clk);
    proc_wr_en = 0;
  endtask

  task automatic release_buf();
    @(negedge clk); proc_release = 1;
    @(negedge clk); proc_release = 0;
  endtask

  task automatic pull(input int w0, input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) begin
      int w, s, p;
      w = (w0 + i) % DEPTH; s = w % NCH; p = w / NCH;
      chk("R7 tx valid", tx_valid, 1);
      chk("R7 tx slot order", tx_slot, s);
      chk("R7 tx interleaved word", tx_data, base + DW'(s * LEN + p));
      tx_ready = 1;
      @(negedge clk);
      tx_ready = 0;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R11 rx ready low in reset", rx_ready, 0);
    chk("R1 ready idle", buf_ready, 0);
    chk("R1 overrun idle", overrun, 0);
    chk("R1 tx valid idle", tx_valid, 0);
    chk("R1 index idle", buf_idx, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 rx ready after reset", rx_ready, 1);
    chk("R1 tx valid still low", tx_valid, 0);
  endtask

  task automatic t_first_fill();
    fill(16'h1000, 0, 1'b0, 1'b0, 0, '0);
    proc_fill(16'hA000);
    release_buf();
  endtask

  task automatic t_bad_slot();
    fill(16'h2000, 1, 1'b1, 1'b0, 1, 16'h1000);
  endtask

  task automatic t_tx_stream();
    @(negedge clk);
    pull(0, DEPTH + 2, 16'hA000);
  endtask

  task automatic t_backpressure();
    logic [DW-1:0] d0;
    logic [SW-1:0] s0;
    d0 = tx_data; s0 = tx_slot;
    repeat (4) begin
      @(negedge clk);
      chk("R8 tx data held", tx_data, d0);
      chk("R8 tx slot held", tx_slot, s0);
    end
  endtask

  task automatic t_swap_overrun();
    proc_fill(16'hB000);
    pull(2, 5, 16'hA000);
    fill(16'h3000, 0, 1'b0, 1'b1, 1, 16'h2000);
    chk("R9 restart at slot 0", tx_slot, 0);
    chk("R9 restart word", tx_data, 16'hB000);
    pull(0, 3, 16'hB000);
    release_buf();
    fill(16'h4000, 0, 1'b1, 1'b0, 1, 16'h3000);
    chk("R6 tx follows buffer 0 again", tx_data, 16'hA000);
  endtask

  initial begin
    t_reset();
    t_first_fill();
    t_bad_slot();
    t_tx_stream();
    t_backpressure();
    t_swap_overrun();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1-wide run: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule